// File: doc/BRIEF.md
# Predicated Pairwise Unsigned Minimum Unit

This block is a vector datapath stage that reduces adjacent pairs of unsigned elements to their minimum. Two operand vectors, A and B, of a compile-time length arrive with a per-byte predicate mask and a two-bit element-size code. Each result lane with an even index takes the smaller of two neighbouring elements of A. Each result lane with an odd index takes the smaller of two neighbouring elements of B. The results from the two operands therefore come out interleaved.

The predicate merges the result into A. A lane whose predicate is clear passes A's element through unchanged, so the output can be written back over A. When no lane is active at the selected size, B is forced to zero before use. Inputs are sampled with a valid strobe, and the result appears on registered outputs one clock later.

Top module: `pairmin_merge_unit`

## Requirements
- R1: The size code selects the element width as 8 << code: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. There are VLEN/width lanes, and lane e occupies bits [e*width +: width].
- R2: For an active even lane e, the result is the unsigned minimum of A elements e and e+1.
- R3: For an active odd lane e, the result is the unsigned minimum of B elements e-1 and e.
- R4: Lane e is active exactly when predicate bit e*(width/8) is 1, which is the bit of the lane's lowest byte. The other predicate bits of that lane have no effect.
- R5: An inactive lane outputs A's element at the same index.
- R6: When no lane is active at the selected size, B is treated as all zeros and the whole output equals A.
- R7: Comparisons are unsigned, so 8'h7F is smaller than 8'h80. Each result is exactly one element wide.
- R8: out_valid is 1 in the cycle after a cycle with in_valid = 1, and is 0 in the cycle after a cycle with in_valid = 0.
- R9: A synchronous active-high reset sets out_valid and out_data to zero.
- R10: out_data keeps its value across cycles in which in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the inputs as a new operation |
| in_op_a | input | VLEN | Operand A, the even-lane source and the merge value |
| in_op_b | input | VLEN | Operand B, the odd-lane source |
| in_pred | input | VLEN/8 | Predicate mask, one bit per byte |
| in_size | input | 2 | Element-size code |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | VLEN | Registered merged result |

## Verification
The bench drives a predicate that sets only the non-lowest bytes of each lane. A design that decoded the wrong predicate bit would then modify lanes that must pass A through unchanged. Alternating 8'h80 and 8'h7F operands expose a signed compare, which would return the wrong element of each pair. Every size code is run with full, empty and random masks, so a swapped even/odd source or a wrong lane stride shows up as lanes taken from the wrong operand. Idle gaps between operations show whether a design lets the registered result drift or holds valid high for too long.

// File: rtl/pairmin_pkg.sv
package pairmin_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_t;

  localparam int unsigned NUM_SIZES = 4;

  // element width in bits for a size code
  function automatic int unsigned esz_bits(input int unsigned code);
    return 8 << code;
  endfunction

endpackage

// File: rtl/pairmin_any_active.sv
module pairmin_any_active #(
  parameter int unsigned VLEN  = 256,
  parameter int unsigned EBITS = 8
) (
  input  logic [VLEN/8-1:0]     pred,
  output logic [VLEN/EBITS-1:0] lane_act,
  output logic                  any_act
);
  localparam int unsigned NELEM  = VLEN / EBITS;
  localparam int unsigned STRIDE = EBITS / 8;

  // only the lowest byte of each element carries its activity bit
  for (genvar e = 0; e < NELEM; e++) begin : g_lead
    assign lane_act[e] = pred[e*STRIDE];
  end

  assign any_act = |lane_act;

  logic unused_pred_bits;
  assign unused_pred_bits = ^pred;

endmodule

// File: rtl/pairmin_lane_min.sv
module pairmin_lane_min #(
  parameter int unsigned EBITS = 8
) (
  input  logic [EBITS-1:0] lhs,
  input  logic [EBITS-1:0] rhs,
  output logic [EBITS-1:0] smaller
);
  assign smaller = (lhs < rhs) ? lhs : rhs;
endmodule

// File: rtl/pairmin_size_path.sv
module pairmin_size_path #(
  parameter int unsigned VLEN  = 256,
  parameter int unsigned EBITS = 8
) (
  input  logic [VLEN-1:0]   op_a,
  input  logic [VLEN-1:0]   op_b,
  input  logic [VLEN/8-1:0] pred,
  output logic [VLEN-1:0]   merged
);
  localparam int unsigned NELEM = VLEN / EBITS;

  logic [NELEM-1:0] lane_act;
  logic             any_act;
  logic [VLEN-1:0]  b_eff;

  pairmin_any_active #(.VLEN(VLEN), .EBITS(EBITS)) u_act (
    .pred     (pred),
    .lane_act (lane_act),
    .any_act  (any_act)
  );

  // second operand is zeroed when nothing is active at this size
  assign b_eff = any_act ? op_b : '0;

  for (genvar e = 0; e < NELEM; e++) begin : g_lane
    logic [EBITS-1:0] pair_min;
    if ((e % 2) == 0) begin : g_even
      pairmin_lane_min #(.EBITS(EBITS)) u_min (
        .lhs     (op_a[e*EBITS     +: EBITS]),
        .rhs     (op_a[(e+1)*EBITS +: EBITS]),
        .smaller (pair_min)
      );
    end else begin : g_odd
      pairmin_lane_min #(.EBITS(EBITS)) u_min (
        .lhs     (b_eff[(e-1)*EBITS +: EBITS]),
        .rhs     (b_eff[e*EBITS     +: EBITS]),
        .smaller (pair_min)
      );
    end
    assign merged[e*EBITS +: EBITS] = lane_act[e] ? pair_min
                                                   : op_a[e*EBITS +: EBITS];
  end

endmodule

// File: rtl/pairmin_merge_unit.sv
module pairmin_merge_unit
  import pairmin_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VLEN-1:0]   in_op_a,
  input  logic [VLEN-1:0]   in_op_b,
  input  logic [VLEN/8-1:0] in_pred,
  input  logic [1:0]        in_size,
  output logic              out_valid,
  output logic [VLEN-1:0]   out_data
);

  if ((VLEN % 128) != 0) begin : g_bad_vlen
    $error("VLEN must be a multiple of 128");
  end

  logic [VLEN-1:0] path_res [NUM_SIZES];
  logic [VLEN-1:0] sel_res;

  // one datapath per element size, selected afterwards
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    pairmin_size_path #(.VLEN(VLEN), .EBITS(esz_bits(g))) u_path (
      .op_a   (in_op_a),
      .op_b   (in_op_b),
      .pred   (in_pred),
      .merged (path_res[g])
    );
  end

  always_comb begin
    sel_res = path_res[in_size];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sel_res;
    end
  end

endmodule

// File: rtl/pairmin_checker.sv
module pairmin_checker #(
  parameter int unsigned VLEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [VLEN-1:0]   in_op_a,
  input logic [VLEN-1:0]   in_op_b,
  input logic [VLEN/8-1:0] in_pred,
  input logic [1:0]        in_size,
  input logic              out_valid,
  input logic [VLEN-1:0]   out_data
);

  function automatic logic [7:0] min8(input logic [7:0] x, input logic [7:0] y);
    return (x < y) ? x : y;
  endfunction

  logic unused_chk;
  assign unused_chk = ^{in_op_b, in_op_a};

  p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  p_valid_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  p_even_lane0_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == 2'd0 && in_pred[0]) |=>
      out_data[7:0] == min8($past(in_op_a[7:0]), $past(in_op_a[15:8])));

  p_odd_lane1_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == 2'd0 && in_pred[1]) |=>
      out_data[15:8] == min8($past(in_op_b[7:0]), $past(in_op_b[15:8])));

  p_merge_lane0_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_pred[0]) |=> out_data[7:0] == $past(in_op_a[7:0]));

  p_all_off_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred == '0) |=> out_data == $past(in_op_a));

endmodule

bind pairmin_merge_unit pairmin_checker #(.VLEN(VLEN)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op_a   (in_op_a),
  .in_op_b   (in_op_b),
  .in_pred   (in_pred),
  .in_size   (in_size),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_pairmin_merge_unit.sv
`timescale 1ns/1ps
module test_pairmin_merge_unit;
  localparam int unsigned VLEN = 256;
  localparam int unsigned PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [VLEN-1:0] in_op_a = '0;
  logic [VLEN-1:0] in_op_b = '0;
  logic [PW-1:0]   in_pred = '0;
  logic [1:0]      in_size = '0;
  logic            out_valid;
  logic [VLEN-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic            mdl_valid = 1'b0;
  logic [VLEN-1:0] mdl_data  = '0;
  string           mdl_tag   = "R9";

  always #2.5 clk = ~clk;

  pairmin_merge_unit #(.VLEN(VLEN)) i_pairmin_merge_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op_a(in_op_a),
    .in_op_b(in_op_b), .in_pred(in_pred), .in_size(in_size),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] get_elem(input logic [VLEN-1:0] v, input int idx, input int w);
    logic [63:0] r = '0;
    for (int k = 0; k < w; k++) r[k] = v[idx*w + k];
    return r;
  endfunction

  function automatic logic [VLEN-1:0] ref_model(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                                input logic [PW-1:0] p, input logic [1:0] sz);
    int w = 8 << sz;
    int n = VLEN / w;
    bit any = 0;
    logic [VLEN-1:0] r = '0;
    logic [63:0] x, y, m;
    for (int e = 0; e < n; e++) if (p[e*(w/8)]) any = 1;
    if (!any) b = '0;
    for (int e = 0; e < n; e++) begin
      if (!p[e*(w/8)]) m = get_elem(a, e, w);
      else begin
        if (e % 2 == 0) begin x = get_elem(a, e, w); y = get_elem(a, e+1, w); end
        else            begin x = get_elem(b, e-1, w); y = get_elem(b, e, w); end
        m = (x < y) ? x : y;
      end
      for (int k = 0; k < w; k++) r[e*w + k] = m[k];
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PW-1:0] rnd_pred();
    logic [PW-1:0] v;
    for (int i = 0; i < PW; i++) v[i] = $urandom_range(0, 1);
    return v;
  endfunction

  task automatic check_outputs();
    checks++;
    if (out_valid !== mdl_valid) begin
      fails++;
      $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, mdl_valid);
    end
    checks++;
    if (out_data !== mdl_data) begin
      fails++;
      $display("FAIL %s out_data actual=%h expected=%h", mdl_tag, out_data, mdl_data);
    end
  endtask

  task automatic step(input bit v, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                      input logic [PW-1:0] p, input logic [1:0] sz, input string tag);
    @(negedge clk);
    check_outputs();
    mdl_valid = v;
    if (v) begin
      mdl_data = ref_model(a, b, p, sz);
      mdl_tag  = tag;
    end else begin
      mdl_tag = "R10";
    end
    in_valid = v; in_op_a = a; in_op_b = b; in_pred = p; in_size = sz;
  endtask

  task automatic idle();
    step(1'b0, rnd_vec(), rnd_vec(), rnd_pred(), 2'($urandom_range(0, 3)), "R10");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [VLEN-1:0] a, b;
    logic [PW-1:0] p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: first step checks the reset state
    // R1: random data at each size code
    for (int sz = 0; sz < 4; sz++)
      for (int i = 0; i < 6; i++)
        step(1'b1, rnd_vec(), rnd_vec(), rnd_pred(), 2'(sz), "R1");
    // R2 R3: all lanes active
    for (int sz = 0; sz < 4; sz++) step(1'b1, rnd_vec(), rnd_vec(), '1, 2'(sz), "R2 R3");
    // R6: nothing active, output equals A
    for (int sz = 0; sz < 4; sz++) step(1'b1, rnd_vec(), rnd_vec(), '0, 2'(sz), "R6");
    // R7: unsigned compare
    for (int i = 0; i < VLEN/8; i++) begin
      a[i*8 +: 8] = (i % 2 == 0) ? 8'h80 : 8'h7F;
      b[i*8 +: 8] = (i % 2 == 0) ? 8'h01 : 8'hFF;
    end
    step(1'b1, a, b, '1, 2'd0, "R7");
    idle();
    idle();
    // R4: only non-leading bytes set at 32-bit size, no lane active
    for (int i = 0; i < PW; i++) p[i] = (i % 4 != 0);
    step(1'b1, rnd_vec(), rnd_vec(), p, 2'd2, "R4");
    // R4: only leading bytes set at 64-bit size, every lane active
    for (int i = 0; i < PW; i++) p[i] = (i % 8 == 0);
    step(1'b1, rnd_vec(), rnd_vec(), p, 2'd3, "R4");
    // R5: sparse masks
    for (int sz = 0; sz < 4; sz++) begin
      for (int i = 0; i < PW; i++) p[i] = (i % 3 == 0);
      step(1'b1, rnd_vec(), rnd_vec(), p, 2'(sz), "R5");
    end
    // R10 and R8: idle gap then back-to-back
    idle();
    idle();
    idle();
    step(1'b1, rnd_vec(), rnd_vec(), rnd_pred(), 2'd1, "R1");
    idle();
    idle();
    @(negedge clk);
    check_outputs();
    finish_run();
  end

endmodule